// File: doc/BRIEF.md
# Master Clock Source Controller

This block picks which of five clock sources drives the master clock of a microcontroller. It also decides which oscillators may run. Software writes one configuration word. The word carries a requested mode and three enable bits, one each for the main oscillator, the PLL and the sub oscillator. The block drives an enable line for each of the five sources, a select code for an external glitch-free clock multiplexer, and the current mode. The oscillators themselves are outside the block and report back through one ready line each.

A mode change does not happen at once. The block first turns on the requested source and keeps the old source running. It moves the select only after the new source reports ready. Once the new mode is in force, it switches off in hardware the sources that the mode does not permit. The low-speed RC source is never switched off. The high-speed RC source is switched off only by the two slow modes, never by software.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, the mode and the select are 2 (high-speed RC) and `switching` is 0. The three software enable bits are cleared, so `src_en` is 5'b01100.
- R2: Mode and select codes are 0 = main oscillator, 1 = sub oscillator, 2 = high-speed RC, 3 = low-speed RC and 4 = PLL. Bit i of `src_en` and `src_rdy` belongs to the source with code i.
- R3: A switch accepted at one clock edge enables the target source from then on and keeps the old source's enables. `clk_sel` and `mode_now` take the target code at the first edge where the target's `src_rdy` bit is sampled high, and not before.
- R4: `switching` is 1 from the edge that accepts a mode change until the edge that completes the last pending switch.
- R5: In main-oscillator mode, the main oscillator and both RC sources are on. The PLL and the sub oscillator follow their enable bits.
- R6: In sub-oscillator mode, only the sub oscillator and the low-speed RC are on, whatever the enable bits say.
- R7: In high-speed RC mode, the main oscillator, the PLL and the sub oscillator each follow their own enable bit, and both RC sources are on.
- R8: In low-speed RC mode, the main oscillator, the PLL and the high-speed RC are off, and the sub oscillator follows its enable bit.
- R9: In PLL mode, the PLL, the main oscillator (which feeds it) and both RC sources are on, and the sub oscillator follows its enable bit.
- R10: The source currently selected is always enabled, and the low-speed RC enable is 1 in every state.
- R11: A valid mode written while `switching` is 1 is held, and the latest such write wins. It starts as a new switch when the current one completes, unless it equals the mode just reached.
- R12: A write whose mode field is 5, 6 or 7 leaves the mode and `switching` unchanged. Its enable bits are still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Requested mode code |
| cfg_main_on | input | 1 | Main oscillator enable bit |
| cfg_pll_on | input | 1 | PLL enable bit |
| cfg_sub_on | input | 1 | Sub oscillator enable bit |
| src_rdy | input | 5 | Per-source stable indication |
| src_en | output | 5 | Per-source run enable |
| clk_sel | output | 3 | Master clock select code |
| mode_now | output | 3 | Current mode status |
| switching | output | 1 | Mode change in progress |

## Verification
The bench builds the block with the default `RST_MODE` of 2, so every test starts in high-speed RC mode. From there, each of the other four modes is one write away, and each switch can be held back by keeping its ready bit low. This setup covers the waiting window of a switch, a request queued behind an unfinished switch, and an undefined code written while idle. It also exercises the hardware forced-off rules of the two slow modes, against enable bits that ask for the opposite.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter logic [2:0] RST_MODE = 3'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_mode,
  input  logic       cfg_main_on,
  input  logic       cfg_pll_on,
  input  logic       cfg_sub_on,
  input  logic [4:0] src_rdy,
  output logic [4:0] src_en,
  output logic [2:0] clk_sel,
  output logic [2:0] mode_now,
  output logic       switching
);

  localparam logic [2:0] M_MAIN = 3'd0;
  localparam logic [2:0] M_SUB  = 3'd1;
  localparam logic [2:0] M_HRC  = 3'd2;
  localparam logic [2:0] M_LRC  = 3'd3;
  localparam logic [2:0] M_PLL  = 3'd4;

  logic [2:0] cur, tgt, q_mode, q_mode_n;
  logic       busy, q_vld, q_vld_n;
  logic       on_main, on_pll, on_sub;
  logic       wr_ok, tgt_rdy;
  logic [4:0] mode_en, need_en;

  assign wr_ok    = cfg_we && (cfg_mode <= M_PLL);
  assign tgt_rdy  = src_rdy[tgt];
  assign q_vld_n  = q_vld | wr_ok;
  assign q_mode_n = wr_ok ? cfg_mode : q_mode;

  // bit order: {pll, lrc, hrc, sub, main}
  always_comb begin
    case (cur)
      M_MAIN:  mode_en = {on_pll, 1'b1, 1'b1, on_sub, 1'b1};
      M_SUB:   mode_en = 5'b01010;
      M_LRC:   mode_en = {1'b0, 1'b1, 1'b0, on_sub, 1'b0};
      M_PLL:   mode_en = {1'b1, 1'b1, 1'b1, on_sub, 1'b1};
      default: mode_en = {on_pll, 1'b1, 1'b1, on_sub, on_main};
    endcase
  end

  always_comb begin
    need_en = '0;
    if (busy) begin
      need_en[tgt] = 1'b1;
      if (tgt == M_PLL) need_en[M_MAIN] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= RST_MODE;
      tgt     <= RST_MODE;
      busy    <= 1'b0;
      q_vld   <= 1'b0;
      q_mode  <= RST_MODE;
      on_main <= 1'b0;
      on_pll  <= 1'b0;
      on_sub  <= 1'b0;
    end else begin
      if (cfg_we) begin
        on_main <= cfg_main_on;
        on_pll  <= cfg_pll_on;
        on_sub  <= cfg_sub_on;
      end
      if (!busy) begin
        if (wr_ok && cfg_mode != cur) begin
          tgt  <= cfg_mode;
          busy <= 1'b1;
        end
      end else if (tgt_rdy) begin
        cur   <= tgt;
        q_vld <= 1'b0;
        if (q_vld_n && q_mode_n != tgt) tgt <= q_mode_n;
        else busy <= 1'b0;
      end else begin
        q_vld  <= q_vld_n;
        q_mode <= q_mode_n;
      end
    end
  end

  assign src_en    = mode_en | need_en;
  assign clk_sel   = cur;
  assign mode_now  = cur;
  assign switching = busy;

  AST_SEL_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    src_en[clk_sel] && src_en[M_LRC]); // R10
  AST_SEL_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != $past(clk_sel)) |-> $past(src_rdy[tgt])); // R3
  AST_BUSY_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != $past(clk_sel)) |-> $past(switching)); // R4
  AST_SUB_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == M_SUB && !switching) |-> (src_en == 5'b01010)); // R6
  AST_LRC_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == M_LRC && !switching) |-> (!src_en[0] && !src_en[2] && !src_en[4])); // R8
  AST_PLL_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == M_PLL) |-> (src_en[0] && src_en[4])); // R9
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!switching && cfg_we && cfg_mode > M_PLL) |=> (!switching && $stable(mode_now))); // R12

endmodule

// File: tb/test_clk_mode_ctrl.sv
module test_clk_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic       cfg_main_on = 1'b0, cfg_pll_on = 1'b0, cfg_sub_on = 1'b0;
  logic [4:0] src_rdy = '0;
  logic [4:0] src_en;
  logic [2:0] clk_sel, mode_now;
  logic       switching;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  clk_mode_ctrl i_clk_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_main_on(cfg_main_on), .cfg_pll_on(cfg_pll_on), .cfg_sub_on(cfg_sub_on),
    .src_rdy(src_rdy), .src_en(src_en), .clk_sel(clk_sel),
    .mode_now(mode_now), .switching(switching));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] m, input logic mn, input logic pl, input logic sb);
    cfg_we = 1'b1; cfg_mode = m; cfg_main_on = mn; cfg_pll_on = pl; cfg_sub_on = sb;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 sel", clk_sel, 2);
    chk("R1 mode", mode_now, 2);
    chk("R1 busy", switching, 0);
    chk("R1 en", src_en, 5'b01100);
  endtask

  task automatic t_hrc_bits;
    src_rdy = 5'b11111;
    wr(3'd2, 1'b1, 1'b0, 1'b1);
    chk("R7 no switch", switching, 0);
    chk("R7 en", src_en, 5'b01111);
    wr(3'd2, 1'b0, 1'b1, 1'b0);
    chk("R7 en2", src_en, 5'b11100);
  endtask

  task automatic t_to_main;
    src_rdy = 5'b00000;
    wr(3'd0, 1'b0, 1'b1, 1'b0);
    chk("R4 busy", switching, 1);
    chk("R3 target on", src_en, 5'b11101);
    repeat (3) @(negedge clk);
    chk("R3 held sel", clk_sel, 2);
    src_rdy = 5'b00001;
    @(negedge clk);
    chk("R3 sel moved", clk_sel, 0);
    chk("R2 mode code", mode_now, 0);
    chk("R4 busy done", switching, 0);
    chk("R5 en", src_en, 5'b11101);
  endtask

  task automatic t_to_sub;
    src_rdy = 5'b00010;
    wr(3'd1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R6 sel", clk_sel, 1);
    chk("R6 en", src_en, 5'b01010);
  endtask

  task automatic t_to_lrc;
    src_rdy = 5'b01000;
    wr(3'd3, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 sel", clk_sel, 3);
    chk("R8 en", src_en, 5'b01000);
    wr(3'd3, 1'b1, 1'b1, 1'b1);
    chk("R8 sub follows", src_en, 5'b01010);
  endtask

  task automatic t_to_pll;
    src_rdy = 5'b00000;
    wr(3'd4, 1'b0, 1'b0, 1'b0);
    chk("R9 wait en", src_en, 5'b11001);
    src_rdy = 5'b10000;
    @(negedge clk);
    chk("R9 sel", clk_sel, 4);
    chk("R9 en", src_en, 5'b11101);
  endtask

  task automatic t_bad_code;
    wr(3'd6, 1'b0, 1'b0, 1'b1);
    chk("R12 busy", switching, 0);
    chk("R12 mode", mode_now, 4);
    chk("R12 bits taken", src_en, 5'b11111);
  endtask

  task automatic t_queue;
    src_rdy = 5'b00000;
    wr(3'd2, 1'b0, 1'b0, 1'b0);
    wr(3'd3, 1'b0, 1'b0, 1'b0);
    wr(3'd1, 1'b0, 1'b0, 1'b0);
    src_rdy = 5'b00100;
    @(negedge clk);
    chk("R11 first done", clk_sel, 2);
    chk("R11 still busy", switching, 1);
    chk("R10 sel on", src_en[2], 1);
    src_rdy = 5'b00110;
    @(negedge clk);
    chk("R11 latest wins", clk_sel, 1);
    chk("R4 idle", switching, 0);
    chk("R10 lrc on", src_en[3], 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hrc_bits();
    t_to_main();
    t_to_sub();
    t_to_lrc();
    t_to_pll();
    t_bad_code();
    t_queue();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule